// File: doc/BRIEF.md
# Serial Receiver with Idle-Line Detection

This block is the receive half of an asynchronous serial port. It watches a single serial input, oversampled by a baud tick that runs at sixteen times the bit rate. It recovers frames of either eight or nine data bits and moves each good frame into a receive data register. When that happens it raises a receive-full flag. Alongside the receiver, a line watcher counts whole bit times of continuous high level. After enough of them it raises an idle flag, and the number needed depends on the frame length.

Software clears each flag with a two-step sequence. First it reads the status register while the flag is set. Then it accesses the data register: a read clears receive-full, and a write clears idle. After an idle report, the idle flag stays quiet until a new good frame has arrived. A wakeup control blocks idle reports while it is high. Status and data are presented continuously on output buses. Strobes mark the cycles in which software reads status, reads data or writes data.

Top module: `serial_rx_idle`

## Requirements
- R1: After reset the status bus reads 0x00, the data bus reads 0x00 and the ninth-bit output reads 0.
- R2: A frame consists of a low start bit, then data bits least significant first, then a high stop bit. With `nine_bit` low it carries 8 data bits. The byte appears on `rx_data`, `rx_bit8` reads 0, and status bit 5 (receive-full) becomes 1.
- R3: With `nine_bit` high a frame carries 9 data bits. The first eight go to `rx_data` and the ninth goes to `rx_bit8`.
- R4: Receive-full clears only when a `data_rd` strobe follows an earlier `stat_rd` strobe that saw it set. A `data_rd` with no such status read leaves it set.
- R5: Status bit 4 (idle) sets once the input has stayed high for 10 whole bit times since the last low sample with `nine_bit` low, or for 11 with `nine_bit` high.
- R6: Idle clears only when a `data_wr` strobe follows an earlier `stat_rd` strobe that saw it set. A `data_rd` does not clear it.
- R7: Idle cannot set again until a good frame has set receive-full. This applies after reset and after each idle report.
- R8: While `wake_en` is high, an idle condition does not set the idle flag. Lowering `wake_en` after the threshold has passed does not set it late.
- R9: Status bits 7, 6 and 3 to 0 always read 0. A `data_wr` does not alter `rx_data` or `rx_bit8`.
- R10: A frame whose stop bit samples low is discarded. Receive-full and the data register keep their previous values.
- R11: A low pulse shorter than half a bit time does not start a frame.
- R12: If a frame completes in the same cycle as a clearing `data_rd`, receive-full stays 1 and the new data is stored. That read's status-read qualification is used up, so a further `data_rd` alone leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idles high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| nine_bit | input | 1 | 0: 8 data bits, 1: 9 data bits |
| wake_en | input | 1 | Receiver wakeup; blocks idle reporting while high |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register low byte read strobe |
| data_wr | input | 1 | Data register low byte write strobe |
| status | output | 8 | Status: bit 5 receive-full, bit 4 idle, others 0 |
| rx_data | output | 8 | Received data, low eight bits |
| rx_bit8 | output | 1 | Ninth received data bit |

## Verification
The collision that matters is a frame transfer that sets receive-full landing in the same cycle as a qualified `data_rd` that would clear it. The bench first measures the fixed delay from start-bit edge to flag rise on a frame aligned to the tick phase. It then arms the clearing sequence with a status read and sends a second aligned frame. The data read is placed exactly in the transfer cycle. The flag must stay set with the new byte on `rx_data`, and a later bare `data_rd` must not clear it.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_WAIT  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  // widest frame payload
  localparam int WORD_W = 9;

  // number of data bits for the selected frame length
  function automatic logic [3:0] data_bits(input logic nine);
    return nine ? 4'd9 : 4'd8;
  endfunction

  // whole high bit times that make an idle line
  function automatic logic [3:0] idle_bits(input logic nine);
    return nine ? 4'd11 : 4'd10;
  endfunction

  // right-shifted capture register to payload: 8-bit frames sit one place high
  function automatic logic [WORD_W-1:0] align_word(input logic [WORD_W-1:0] sh,
                                                   input logic nine);
    return nine ? sh : {1'b0, sh[WORD_W-1:1]};
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '1;
        else        q <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              nine,
  output logic              frame_done,
  output logic [WORD_W-1:0] frame_word
);
  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CNT_W-1:0] PH_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] PH_HALF = CNT_W'(OVS / 2 - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  ph;
  logic [3:0]        nbit;
  logic [WORD_W-1:0] sh;
  logic              nine_l;
  logic              rx_prev;

  // named events for the checks
  logic start_edge, mid_start, bit_slot, stop_slot;
  assign start_edge = tick && (state == RX_WAIT) && rx_prev && !rx;
  assign mid_start  = tick && (state == RX_START) && (ph == PH_HALF);
  assign bit_slot   = tick && (state == RX_DATA) && (ph == PH_LAST);
  assign stop_slot  = tick && (state == RX_STOP) && (ph == PH_LAST);

  assign frame_done = stop_slot && rx;
  assign frame_word = align_word(sh, nine_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_WAIT;
      ph      <= '0;
      nbit    <= '0;
      sh      <= '0;
      nine_l  <= 1'b0;
      rx_prev <= 1'b1;
    end else if (tick) begin
      rx_prev <= rx;
      unique case (state)
        RX_WAIT: begin
          if (start_edge) begin
            state <= RX_START;
            ph    <= '0;
          end
        end
        RX_START: begin
          if (mid_start) begin
            ph   <= '0;
            nbit <= '0;
            if (!rx) begin
              state  <= RX_DATA;
              nine_l <= nine;
            end else begin
              state <= RX_WAIT;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_slot) begin
            sh   <= {rx, sh[WORD_W-1:1]};
            nbit <= nbit + 1'b1;
            ph   <= '0;
            if (nbit == data_bits(nine_l) - 4'd1) state <= RX_STOP;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        RX_STOP: begin
          if (stop_slot) begin
            state <= RX_WAIT;
            ph    <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= RX_WAIT;
      endcase
    end
  end

  // R2: the stop slot is reached only after the full data bit count
  assert_stop_after_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_STOP) |-> (nbit == data_bits(nine_l)));

  // R11: a start that is high again at mid-bit returns to waiting
  assert_glitch_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_start && rx) |=> (state == RX_WAIT));

endmodule

// File: rtl/serial_rx_linewatch.sv
module serial_rx_linewatch
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic nine,
  output logic idle_hit
);
  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CNT_W-1:0] PH_LAST = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] sub;
  logic [3:0]       high_bits;
  logic             bit_done;

  assign bit_done = tick && rx && (sub == PH_LAST);
  assign idle_hit = bit_done && (high_bits == idle_bits(nine) - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub       <= '0;
      high_bits <= '0;
    end else if (tick) begin
      if (!rx) begin
        sub       <= '0;
        high_bits <= '0;
      end else if (sub == PH_LAST) begin
        sub <= '0;
        if (high_bits != 4'hF) high_bits <= high_bits + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  // R5: a low sample restarts the run of high bit times
  assert_low_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rx) |=> (high_bits == 4'd0));

  // R5: the hit coincides with completing the threshold bit time
  assert_hit_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> (high_bits == $past(idle_bits(nine))));

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] frame_word,
  input  logic              idle_hit,
  input  logic              wake,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              data_wr,
  output logic              full,
  output logic              idle,
  output logic [WORD_W-1:0] word_q
);
  logic full_seen, idle_seen, armed;
  logic full_clr, idle_set, idle_clr;

  assign full_clr = data_rd && full_seen;
  assign idle_set = idle_hit && armed && !wake;
  assign idle_clr = data_wr && idle_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      full_seen <= 1'b0;
      idle      <= 1'b0;
      idle_seen <= 1'b0;
      armed     <= 1'b0;
      word_q    <= '0;
    end else begin
      // set has priority over clear
      if (frame_done)    full <= 1'b1;
      else if (full_clr) full <= 1'b0;

      if (frame_done || full_clr) full_seen <= 1'b0;
      else if (stat_rd && full)   full_seen <= 1'b1;

      if (idle_set)      idle <= 1'b1;
      else if (idle_clr) idle <= 1'b0;

      if (idle_set || idle_clr)   idle_seen <= 1'b0;
      else if (stat_rd && idle)   idle_seen <= 1'b1;

      if (frame_done)    armed <= 1'b1;
      else if (idle_set) armed <= 1'b0;

      if (frame_done) word_q <= frame_word;
    end
  end

  assert_full_on_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> full);

  assert_full_clear_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(data_rd && full_seen));

  assert_idle_clear_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(data_wr && idle_seen));

  assert_idle_needs_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(armed));

  assert_idle_wake_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> !$past(wake));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(word_q));

  assert_collide_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && data_rd) |=> (full && !full_seen));

endmodule

// File: rtl/serial_rx_idle.sv
module serial_rx_idle
  import serial_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       baud_tick,
  input  logic       nine_bit,
  input  logic       wake_en,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  logic       data_wr,
  output logic [7:0] status,
  output logic [7:0] rx_data,
  output logic       rx_bit8
);
  logic              rx_s;
  logic              frame_done;
  logic [WORD_W-1:0] frame_word;
  logic              idle_hit;
  logic              full, idle;
  logic [WORD_W-1:0] word_q;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  serial_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx(rx_s), .nine(nine_bit),
    .frame_done(frame_done), .frame_word(frame_word)
  );

  serial_rx_linewatch #(.OVS(OVS)) u_line (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx(rx_s), .nine(nine_bit),
    .idle_hit(idle_hit)
  );

  serial_rx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_word(frame_word),
    .idle_hit(idle_hit), .wake(wake_en), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .full(full), .idle(idle), .word_q(word_q)
  );

  assign status  = {2'b00, full, idle, 4'b0000};
  assign rx_data = word_q[7:0];
  assign rx_bit8 = word_q[8];

  // R10: a frame whose stop bit is low never transfers
  assert_bad_stop_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> rx_s);

endmodule

// File: tb/tb_serial_rx_idle.sv
module tb_serial_rx_idle;
  localparam int BITC = 64; // 16 ticks x 4 clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic nine_bit = 1'b0, wake_en = 1'b0;
  logic stat_rd = 1'b0, data_rd = 1'b0, data_wr = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic baud_tick;
  logic [7:0] status, rx_data;
  logic rx_bit8;

  int checks = 0, errors = 0;
  int cyc = 0;
  int frame_start_cyc = 0, frame_count = 0, lat = 0, rise_cyc = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);

  serial_rx_idle dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
    .nine_bit(nine_bit), .wake_en(wake_en), .stat_rd(stat_rd),
    .data_rd(data_rd), .data_wr(data_wr), .status(status),
    .rx_data(rx_data), .rx_bit8(rx_bit8)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every rise of receive-full pops one expected word
  always @(negedge clk) begin : monitor
    logic prev_full;
    logic [8:0] e;
    prev_full = 1'b0;
    forever begin
      @(negedge clk);
      if (status[5] && !prev_full) begin
        rise_cyc = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", {rx_bit8, rx_data}, 0);
        end else begin
          e = exp_q.pop_front();
          chk({rx_bit8, rx_data} == e, "R2 R3 scoreboard word", {rx_bit8, rx_data}, e);
        end
      end
      prev_full = status[5];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_bits(input int tenths);
    repeat (tenths * BITC / 10) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] w, input bit nine, input bit stop, input bit push);
    @(negedge clk);
    while (tdiv != 2'd0) @(negedge clk);
    if (push && stop) exp_q.push_back(nine ? w : {1'b0, w[7:0]});
    frame_start_cyc = cyc;
    frame_count++;
    rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxd = w[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = stop;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask
  task automatic pulse_rd();
    @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
  endtask
  task automatic pulse_wr();
    @(negedge clk); data_wr = 1'b1; @(negedge clk); data_wr = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 8'h00, "R1 status after reset", status, 0);
    chk(rx_data == 8'h00 && rx_bit8 == 1'b0, "R1 data after reset", {rx_bit8, rx_data}, 0);

    // R7 never-active line does not report idle
    wait_bits(150);
    chk(status[4] == 1'b0, "R7 idle before any frame", status[4], 0);

    // R2 8-bit frame, last data bit low; measure latency
    send_frame(9'h035, 1'b0, 1'b1, 1'b1);
    lat = rise_cyc - frame_start_cyc;
    chk(status[5] == 1'b1, "R2 full after frame", status[5], 1);
    chk(rx_bit8 == 1'b0, "R2 ninth bit zero in 8-bit mode", rx_bit8, 0);

    // R5 idle threshold, 8-bit mode (one high bit time already elapsed)
    wait_bits(80);
    chk(status[4] == 1'b0, "R5 idle not yet at 9 bits", status[4], 0);
    wait_bits(15);
    chk(status[4] == 1'b1, "R5 idle at 10 bits", status[4], 1);
    chk((status & 8'hCF) == 8'h00, "R9 unused status bits", status, 0);

    // R4 bare data read does not clear
    pulse_rd();
    @(negedge clk);
    chk(status[5] == 1'b1, "R4 data read without status read", status[5], 1);
    pulse_stat();
    pulse_rd();
    @(negedge clk);
    chk(status[5] == 1'b0, "R4 full cleared by sequence", status[5], 0);
    // R6 data read leaves idle set
    chk(status[4] == 1'b1, "R6 idle survives data read", status[4], 1);
    pulse_wr();
    @(negedge clk);
    chk(status[4] == 1'b0, "R6 idle cleared by write", status[4], 0);
    chk(rx_data == 8'h35, "R9 data write leaves data", rx_data, 8'h35);

    // R7 no re-report without a frame
    wait_bits(150);
    chk(status[4] == 1'b0, "R7 idle after clear without frame", status[4], 0);

    // R3 nine-bit frame with ninth bit high
    nine_bit = 1'b1;
    send_frame(9'h15A, 1'b1, 1'b1, 1'b1);
    chk(rx_bit8 == 1'b1 && rx_data == 8'h5A, "R3 nine-bit word", {rx_bit8, rx_data}, 9'h15A);
    wait_bits(140);
    pulse_stat(); pulse_rd(); pulse_wr();
    send_frame(9'h0C3, 1'b1, 1'b1, 1'b1);
    wait_bits(95);
    chk(status[4] == 1'b0, "R5 nine-bit idle not at 10 bits", status[4], 0);
    wait_bits(10);
    chk(status[4] == 1'b1, "R5 nine-bit idle at 11 bits", status[4], 1);
    pulse_stat(); pulse_rd(); pulse_wr();
    nine_bit = 1'b0;

    // R8 wakeup blocks idle, and no late set after release
    wake_en = 1'b1;
    send_frame(9'h021, 1'b0, 1'b1, 1'b1);
    wait_bits(140);
    chk(status[4] == 1'b0, "R8 idle blocked by wakeup", status[4], 0);
    wake_en = 1'b0;
    wait_bits(30);
    chk(status[4] == 1'b0, "R8 no late idle after release", status[4], 0);
    pulse_stat(); pulse_rd();
    send_frame(9'h012, 1'b0, 1'b1, 1'b1);
    wait_bits(120);
    chk(status[4] == 1'b1, "R8 idle after wakeup low", status[4], 1);
    pulse_stat(); pulse_rd(); pulse_wr();

    // R10 low stop bit discards the frame
    send_frame(9'h044, 1'b0, 1'b0, 1'b0);
    wait_bits(30);
    chk(status[5] == 1'b0, "R10 no full on bad stop", status[5], 0);
    chk(rx_data == 8'h12, "R10 data kept on bad stop", rx_data, 8'h12);

    // R11 short glitch ignored, then a good frame still received
    @(negedge clk);
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    wait_bits(30);
    chk(status[5] == 1'b0 && rx_data == 8'h12, "R11 glitch ignored", {status[5], rx_data}, 9'h012);
    send_frame(9'h05C, 1'b0, 1'b1, 1'b1);
    chk(rx_data == 8'h5C, "R11 frame after glitch", rx_data, 8'h5C);

    // R12 set and clear collide
    pulse_stat();
    fork
      send_frame(9'h06B, 1'b0, 1'b1, 1'b0);
      begin
        int k0;
        k0 = frame_count;
        wait (frame_count == k0 + 1);
        while (cyc != frame_start_cyc + lat - 1) @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        chk(status[5] == 1'b1, "R12 full kept on collision", status[5], 1);
        chk(rx_data == 8'h6B, "R12 new data on collision", rx_data, 8'h6B);
      end
    join
    pulse_rd();
    @(negedge clk);
    chk(status[5] == 1'b1, "R12 bare read after collision", status[5], 1);
    pulse_stat(); pulse_rd();
    @(negedge clk);
    chk(status[5] == 1'b0, "R12 full clears after fresh status read", status[5], 0);

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule